// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each request line is turned into a pending bit. The trigger-mode mask picks, line by line, whether a pending bit follows a rising edge or tracks the line level. Lines that software has masked stay pending but cannot compete.

The block keeps a set of in-service lines. It ranks the candidates against a rotatable priority base. It raises the processor request only when the best candidate strictly outranks the best line already in service.

An acknowledge from the processor marks the line on offer as in service. The same acknowledge retires an edge-triggered request. With rotation on acknowledge enabled, it also moves the priority base to just past that line. End-of-service clears arrive as a bit vector from the surrounding command logic. On a master unit, a fully-nested option leaves the cascade line out of the in-service comparison.

Top module: `prio_irq_core`

## Requirements
- R1: A synchronous reset clears the pending, in-service, mask and previous-level registers, sets the priority base to 0 and drives `irq_out`, `win_valid` and `win_line` to 0.
- R2: On a line whose `trig_mode` bit is 0 (edge), the pending bit is set only when the line is 1 and was 0 at the previous clock edge. Holding the line high does not set it again after an acknowledge has cleared it.
- R3: On a line whose `trig_mode` bit is 1 (level), the pending bit equals the line level sampled at each clock edge. When the line drops, the request disappears.
- R4: A line whose mask bit is 1 can never be the winner. Its pending bit is kept, so clearing the mask bit makes the request visible again.
- R5: Line L has priority slot (L - base) mod 8, and slot 0 is the highest. The winner is the unmasked pending line with the lowest slot.
- R6: `win_valid` is 1 exactly when at least one unmasked pending line exists. When it is 0, `win_line` is 0.
- R7: `irq_out` is 1 only when the winner's slot is strictly lower than the lowest slot found among in-service lines. An equal or higher slot gives `win_valid`=1 with `irq_out`=0.
- R8: An `ack` pulse sampled while `irq_out` is 1 sets the in-service bit of the line shown on `win_line`. On an edge line it also clears the pending bit; on a level line the pending bit is kept. An `ack` sampled while `irq_out` is 0 changes nothing.
- R9: When `aeoi_rot_en` is 1, an accepted acknowledge of line L sets the priority base to (L + 1) mod 8.
- R10: On a master instance with `sfn_en`=1, the cascade line (line 2) is excluded from the in-service side of the comparison. A request on line 2 can therefore interrupt while line 2 is already in service.
- R11: Each bit set in `eoi_clr` clears that in-service bit at the next clock edge.
- R12: `mask_we` loads `mask_wdata` and `base_we` loads `base_wdata`. A base write takes precedence over a rotation from the same cycle. Any change to the internal registers is visible on the outputs one clock edge after it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N | Interrupt request lines |
| trig_mode | input | N | Per-line trigger mode: 0 edge, 1 level |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | N | New mask; 1 blocks a line |
| base_we | input | 1 | Load the priority base |
| base_wdata | input | log2(N) | New priority base |
| eoi_clr | input | N | In-service bits to clear |
| ack | input | 1 | Processor acknowledge pulse |
| sfn_en | input | 1 | Exclude the cascade line from the in-service comparison |
| aeoi_rot_en | input | 1 | Rotate the base on each accepted acknowledge |
| irq_out | output | 1 | Registered processor interrupt request |
| win_valid | output | 1 | Registered flag: a candidate exists |
| win_line | output | log2(N) | Registered winning line number |

## Verification
Most stimuli reach the outputs two clock edges after they are driven. These are the request lines, trigger modes, mask and base writes, end-of-service clears and acknowledges: the first edge updates the internal registers, and the second registers the resolved result. The fully-nested enable feeds the comparison directly, so its effect is due after one edge and holds from then on. The driver queues each expectation with its due cycle. It holds inputs until that cycle has passed, and the monitor compares on the falling edge of the exact cycle named in the queue entry.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // meaning of one trig_mode bit
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/prio_req_latch.sv
// Pending-request register with per-line edge or level capture.
module prio_req_latch
  import prio_irq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_mode,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q
);

  logic [N-1:0] last_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        irr_q[g]  <= 1'b0;
        last_q[g] <= 1'b0;
      end else begin
        last_q[g] <= req_in[g];
        if (trig_e'(trig_mode[g]) == TRIG_LEVEL) begin
          irr_q[g] <= req_in[g];
        end else if (req_in[g] && !last_q[g]) begin
          irr_q[g] <= 1'b1;          // a fresh edge beats a same-cycle clear
        end else if (ack_clr[g]) begin
          irr_q[g] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/prio_scan.sv
// Combinational rotated priority search: slot index and physical line.
module prio_scan #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW:0]   slot,
  output logic [IW-1:0] line
);

  always_comb begin
    logic [IW-1:0] idx;
    slot = (IW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      idx = IW'(k) + base;
      if (vec[idx]) slot = (IW+1)'(k);
    end
    found = !slot[IW];
    line  = slot[IW-1:0] + base;
  end

endmodule

// File: rtl/prio_svc_track.sv
// In-service register and priority base.
module prio_svc_track #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  ack_set,
  input  logic [N-1:0]  eoi_clr,
  input  logic          base_we,
  input  logic [IW-1:0] base_wdata,
  input  logic          rot_we,
  input  logic [IW-1:0] rot_val,
  output logic [N-1:0]  isr_q,
  output logic [IW-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
      if (base_we)     base_q <= base_wdata;
      else if (rot_we) base_q <= rot_val;
    end
  end

endmodule

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
  parameter int N            = 8,
  parameter int CASCADE_LINE = 2,
  parameter bit IS_MASTER    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_in,
  input  logic [N-1:0]         trig_mode,
  input  logic                 mask_we,
  input  logic [N-1:0]         mask_wdata,
  input  logic                 base_we,
  input  logic [$clog2(N)-1:0] base_wdata,
  input  logic [N-1:0]         eoi_clr,
  input  logic                 ack,
  input  logic                 sfn_en,
  input  logic                 aeoi_rot_en,
  output logic                 irq_out,
  output logic                 win_valid,
  output logic [$clog2(N)-1:0] win_line
);

  localparam int IW = $clog2(N);

  logic [N-1:0]  irr_q, isr_q, imr_q;
  logic [IW-1:0] base_q;
  logic [N-1:0]  cand, isr_cmp, ack_set, ack_clr;
  logic          ack_take;
  logic          req_found, svc_found;
  logic [IW:0]   req_slot, svc_slot;
  logic [IW-1:0] req_line, svc_line;
  logic          beat;

  // mask register
  always_ff @(posedge clk) begin
    if (rst)          imr_q <= '0;
    else if (mask_we) imr_q <= mask_wdata;
  end

  // acknowledge acts on the line the processor currently sees
  assign ack_take = ack && irq_out;
  assign ack_set  = ack_take ? (N'(1) << win_line) : '0;
  assign ack_clr  = ack_set & ~trig_mode;

  prio_req_latch #(.N(N)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .req_in    (req_in),
    .trig_mode (trig_mode),
    .ack_clr   (ack_clr),
    .irr_q     (irr_q)
  );

  prio_svc_track #(.N(N), .IW(IW)) u_svc (
    .clk        (clk),
    .rst        (rst),
    .ack_set    (ack_set),
    .eoi_clr    (eoi_clr),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .rot_we     (ack_take && aeoi_rot_en),
    .rot_val    (win_line + 1'b1),
    .isr_q      (isr_q),
    .base_q     (base_q)
  );

  assign cand = irr_q & ~imr_q;

  if (IS_MASTER) begin : g_master
    logic [N-1:0] casc_bit;
    assign casc_bit = N'(1) << CASCADE_LINE;
    assign isr_cmp  = sfn_en ? (isr_q & ~casc_bit) : isr_q;
  end else begin : g_slave
    assign isr_cmp = isr_q;
  end

  prio_scan #(.N(N), .IW(IW)) u_req_scan (
    .vec   (cand),
    .base  (base_q),
    .found (req_found),
    .slot  (req_slot),
    .line  (req_line)
  );

  prio_scan #(.N(N), .IW(IW)) u_svc_scan (
    .vec   (isr_cmp),
    .base  (base_q),
    .found (svc_found),
    .slot  (svc_slot),
    .line  (svc_line)
  );

  // an empty in-service set scans to slot N, which every candidate beats
  assign beat = req_found && (req_slot < svc_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      win_valid <= 1'b0;
      win_line  <= '0;
    end else begin
      irq_out   <= beat;
      win_valid <= req_found;
      win_line  <= req_found ? req_line : '0;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{svc_found, svc_line};

endmodule

// File: rtl/prio_irq_core_chk.sv
module prio_irq_core_chk #(
  parameter int N = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          base_we,
  input logic          aeoi_rot_en,
  input logic          irq_out,
  input logic          win_valid,
  input logic [IW-1:0] win_line,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  imr_q,
  input logic [IW-1:0] base_q
);

  logic [N-1:0] imr_d;
  always_ff @(posedge clk) begin
    if (rst) imr_d <= '0;
    else     imr_d <= imr_q;
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (isr_q == '0 && imr_q == '0 && base_q == '0));

  p_masked_never_wins_r4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !imr_d[win_line]);

  p_irq_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> win_valid);

  p_ack_sets_isr_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out) |=> isr_q[$past(win_line)]);

  p_rotate_on_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out && aeoi_rot_en && !base_we) |=> (base_q == IW'($past(win_line) + 1'b1)));

endmodule

bind prio_irq_core prio_irq_core_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ack         (ack),
  .base_we     (base_we),
  .aeoi_rot_en (aeoi_rot_en),
  .irq_out     (irq_out),
  .win_valid   (win_valid),
  .win_line    (win_line),
  .isr_q       (isr_q),
  .imr_q       (imr_q),
  .base_q      (base_q)
);

// File: tb/sim_prio_irq_core.sv
module sim_prio_irq_core;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_in = '0, trig_mode = '0, mask_wdata = '0, eoi_clr = '0;
  logic          mask_we = 1'b0, base_we = 1'b0, ack = 1'b0;
  logic          sfn_en = 1'b0, aeoi_rot_en = 1'b0;
  logic [IW-1:0] base_wdata = '0;
  logic          irq_out, win_valid;
  logic [IW-1:0] win_line;

  always #4 clk = ~clk;   // 125 MHz

  prio_irq_core #(.N(N)) u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_mode(trig_mode),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .base_we(base_we),
    .base_wdata(base_wdata), .eoi_clr(eoi_clr), .ack(ack),
    .sfn_en(sfn_en), .aeoi_rot_en(aeoi_rot_en),
    .irq_out(irq_out), .win_valid(win_valid), .win_line(win_line)
  );

  typedef struct {
    int            due;
    bit            irq;
    bit            vld;
    logic [IW-1:0] line;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each expectation at its due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (irq_out !== e.irq || win_valid !== e.vld || win_line !== e.line) begin
        errors++;
        $display("FAIL %s: got irq=%0b valid=%0b line=%0d exp irq=%0b valid=%0b line=%0d",
                 e.tag, irq_out, win_valid, win_line, e.irq, e.vld, e.line);
      end
    end
  end

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic push(int lat, bit irq, bit vld, logic [IW-1:0] line, string tag);
    exp_t e;
    e.due = cyc + lat; e.irq = irq; e.vld = vld; e.line = line; e.tag = tag;
    sb.push_back(e);
  endtask

  // inputs are already driven; expect a result lat edges later, clear pulses
  task automatic step(int lat, bit irq, bit vld, logic [IW-1:0] line, string tag);
    push(lat, irq, vld, line, tag);
    nxt();
    ack = 1'b0; mask_we = 1'b0; base_we = 1'b0; eoi_clr = '0;
    nxt();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst = 1'b0;
    push(0, 0, 0, 0, "R1 reset state");
    nxt();

    req_in = 8'b0010_0000;                        step(2, 1, 1, 5, "R2 edge on line 5");
    req_in = 8'b0010_1000;                        step(2, 1, 1, 3, "R5 line 3 beats 5 at base 0");
    ack = 1'b1;                                   step(2, 0, 1, 5, "R8/R7 ack 3, 5 below in-service");
    push(2, 0, 1, 5, "R2 held line 3 does not re-set");
    nxt(); nxt();
    eoi_clr = 8'b0000_1000;                       step(2, 1, 1, 5, "R11 end of service on 3");
    mask_we = 1'b1; mask_wdata = 8'b0010_0000;    step(2, 0, 0, 0, "R4/R6 masked line 5, none left");
    mask_we = 1'b1; mask_wdata = 8'b0000_0000;    step(2, 1, 1, 5, "R4 request kept under mask");
    ack = 1'b1; req_in = '0;                      step(2, 0, 0, 0, "R8 edge ack clears pending");
    eoi_clr = 8'b0010_0000;                       step(2, 0, 0, 0, "R11 clear 5, nothing pending");

    trig_mode = 8'b0000_0001; req_in = 8'b0000_0001;
                                                  step(2, 1, 1, 0, "R3 level line 0");
    ack = 1'b1;                                   step(2, 0, 1, 0, "R8 level ack keeps pending");
    req_in = '0;                                  step(2, 0, 0, 0, "R3 level drop removes request");
    eoi_clr = 8'b0000_0001;                       step(2, 0, 0, 0, "R11 clear 0");
    ack = 1'b1;                                   step(2, 0, 0, 0, "R8 ack without irq ignored");
    req_in = 8'b0100_0000;                        step(2, 1, 1, 6, "R8 no stray in-service after ignored ack");

    aeoi_rot_en = 1'b1; ack = 1'b1;               step(2, 0, 0, 0, "R9 ack 6 with rotation");
    aeoi_rot_en = 1'b0; req_in = 8'b1100_0010;    step(2, 1, 1, 7, "R9/R5 base 7 favours line 7");
    base_we = 1'b1; base_wdata = 3'd2;            step(2, 0, 1, 7, "R12/R7 base 2, 7 below in-service 6");
    base_we = 1'b1; base_wdata = 3'd0;            step(2, 1, 1, 1, "R12/R5 base 0, line 1 wins");

    eoi_clr = 8'hff; mask_we = 1'b1; mask_wdata = 8'b1111_1011; req_in = 8'b1100_0110;
                                                  step(2, 1, 1, 2, "R4 only line 2 unmasked");
    ack = 1'b1;                                   step(2, 0, 0, 0, "R8 ack line 2");
    req_in = 8'b1100_0010;                        step(2, 0, 0, 0, "R2 line 2 drops");
    req_in = 8'b1100_0110;                        step(2, 0, 1, 2, "R7/R10 line 2 equal to in-service");
    sfn_en = 1'b1;                                step(1, 1, 1, 2, "R10 cascade left out of in-service");

    repeat (3) nxt();
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
    end
    summary();
    $finish;
  end

endmodule